// File: doc/BRIEF.md
# DRAM Cycle Decoder with Parallel Test Mode

This block models the control side of an asynchronous DRAM, seen from inside the device, using a fast system clock. The block samples the row strobe, the column strobe, the write enable, the output enable, the shared address pins and the data input on every clock. It works out what kind of cycle the host started from the state of the strobes at the moment the row strobe falls. A row strobe with the column strobe still high opens a row taken from the address pins. A column strobe already low selects a refresh that takes its row from an internal counter. A column strobe and write enable both already low put the part into a compressed parallel test mode.

Inside an open row, every falling column strobe is one access, so several accesses can share one row as in page mode. Read data stays driven after the column strobe rises and turns off only when both strobes are high. In test mode each written data bit goes to the four cells that differ only in the two lowest column bits. A read then reports, for each bit, whether those four cells agree. A small behavioural cell array holds the data. The decoded cycle type, the test-mode flag and the row used by the latest internal refresh are brought out so that a host can see them.

Top module: `dram_cycle_decoder`

## Requirements
- R1: If the row strobe falls while the column strobe is high, `cyc_type` becomes 2 (row open, no column yet) on the next clock. The first falling column strobe while the row is open changes it to 1 (access). After the row strobe rises it is 0 (idle). A row that closes while still at 2 was a row-only refresh.
- R2: If the row strobe falls while the column strobe is low and write enable is high, `cyc_type` becomes 3 (counter refresh). The address pins are not used.
- R3: If the row strobe falls while the column strobe and write enable are both low, `cyc_type` becomes 4 (test set) and `test_active` becomes 1.
- R4: Each counter refresh and each test-set cycle places the internal counter value on `rfsh_row` and then advances the counter by one. The counter wraps from 2^ROW_BITS-1 to 0. After reset `rfsh_row` reads all ones, so the first refresh reports row 0.
- R5: In normal mode, a falling column strobe with write enable low stores `din` at the open row and the addressed column. It leaves the output off. A later read of that cell returns the stored data.
- R6: Read data stays driven after the column strobe rises while the row strobe stays low. It also stays driven through a refresh that is hidden under a held-low column strobe. It turns off on the clock after both strobes are seen high.
- R7: `dq_oe` is never high while `oe_n` is high.
- R8: In test mode a write ignores the two lowest column address bits and stores each `din` bit into all four cells of that column group. A read then gives 1 on every bit whose four cells hold the same value.
- R9: In test mode a read gives 0 on every bit whose four cells do not all hold the same value.
- R10: Test mode stays set through normal reads and further test-set cycles. It is cleared by a counter refresh (at the falling row strobe) or by a row-only refresh (when its row strobe rises).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| din | input | DQ_W | Write data |
| dout | output | DQ_W | Read data (valid while dq_oe) |
| dq_oe | output | 1 | Output drive enable |
| cyc_type | output | 3 | Decoded cycle: 0 idle, 1 access, 2 row open, 3 counter refresh, 4 test set |
| test_active | output | 1 | Parallel test mode flag |
| rfsh_row | output | ROW_BITS | Row used by the latest counter-driven refresh |

## Verification
The decoder is driven with the three strobe orders at a falling row strobe: column strobe high, column strobe low with write enable high, and both low. This shows that the decision is made only from the state at that edge. Open rows with one write and reads, with and without output enable, separate the row-open state from the access state and show the output-enable gating. A read followed by a hidden refresh shows that the output turns off only on the later of the two rising strobes. In test mode, column groups are filled uniformly by a parallel write and then partly rewritten in normal mode. Reading them back gives both the all-agree and the disagree results. The sequence then enters and leaves test mode by each route, so that the exits can be told apart from the cycles that keep the mode set.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4,
  parameter int DQ_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] addr,
  input  logic [DQ_W-1:0]     din,
  output logic [DQ_W-1:0]     dout,
  output logic                dq_oe,
  output logic [2:0]          cyc_type,
  output logic                test_active,
  output logic [ROW_BITS-1:0] rfsh_row
);
  localparam int CELLS = 1 << (ROW_BITS + COL_BITS);
  localparam logic [2:0] CY_IDLE = 3'd0, CY_ACC = 3'd1, CY_ROW = 3'd2,
                         CY_CBR = 3'd3, CY_TSET = 3'd4;

  logic [DQ_W-1:0]     mem [CELLS];
  logic                ras_q, cas_q, dout_en;
  logic [ROW_BITS-1:0] row_q, cnt_q;
  logic [DQ_W-1:0]     dout_q, grp_or, grp_and;
  logic [COL_BITS-1:0] col_in;

  assign col_in = addr[COL_BITS-1:0];

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire row_open = (cyc_type == CY_ROW) || (cyc_type == CY_ACC);
  wire col_hit  = cas_q & ~cas_n & ~ras_q & ~ras_n & row_open;
  wire wr_hit   = col_hit & ~we_n;
  wire rd_hit   = col_hit & we_n;

  always_comb begin
    for (int i = 0; i < DQ_W; i++) begin
      grp_or[i]  = 1'b0;
      grp_and[i] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        grp_or[i]  = grp_or[i]  | mem[{row_q, col_in[COL_BITS-1:2], 2'(k)}][i];
        grp_and[i] = grp_and[i] & mem[{row_q, col_in[COL_BITS-1:2], 2'(k)}][i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit)
      for (int k = 0; k < 4; k++)
        if (test_active || col_in[1:0] == 2'(k))
          mem[{row_q, col_in[COL_BITS-1:2], 2'(k)}] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q       <= 1'b1;
      cas_q       <= 1'b1;
      cyc_type    <= CY_IDLE;
      test_active <= 1'b0;
      row_q       <= '0;
      cnt_q       <= '0;
      rfsh_row    <= '1;
      dout_q      <= '0;
      dout_en     <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        if (cas_n) begin
          cyc_type <= CY_ROW;
          row_q    <= addr[ROW_BITS-1:0];
        end else begin
          rfsh_row    <= cnt_q;
          cnt_q       <= cnt_q + 1'b1;
          cyc_type    <= we_n ? CY_CBR : CY_TSET;
          test_active <= ~we_n;
        end
      end else if (ras_rise) begin
        if (cyc_type == CY_ROW) test_active <= 1'b0;
        cyc_type <= CY_IDLE;
      end else if (col_hit) begin
        cyc_type <= CY_ACC;
        if (wr_hit) dout_en <= 1'b0;
        else begin
          dout_en <= 1'b1;
          dout_q  <= test_active ? (grp_and | ~grp_or) : mem[{row_q, col_in}];
        end
      end
      if (ras_n && cas_n) dout_en <= 1'b0;
    end
  end

  assign dout  = dout_q;
  assign dq_oe = dout_en & ~oe_n;

  AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !oe_n); // R7
  AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && !cas_n && !we_n) |=> test_active); // R3
  AST_CBR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && !cas_n && we_n) |=> (!test_active && cyc_type == CY_CBR)); // R10
  AST_HIZ_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && cas_n) |=> !dq_oe); // R6
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rfsh_row) |-> rfsh_row == $past(rfsh_row) + 1'b1); // R4
  AST_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && cas_n) |=> cyc_type == CY_ROW); // R1
endmodule

// File: tb/tb_dram_cycle_decoder.sv
`timescale 1ns/1ps
module tb_dram_cycle_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] addr = '0, din = '0;
  logic [3:0] dout, rfsh_row;
  logic dq_oe, test_active;
  logic [2:0] cyc_type;
  int checks = 0, failures = 0;
  bit done = 0;

  dram_cycle_decoder dut (.clk, .rst_n, .ras_n, .cas_n, .we_n, .oe_n, .addr, .din,
    .dout, .dq_oe, .cyc_type, .test_active, .rfsh_row);

  always #2.5 clk = ~clk;

  // behavioural reference
  int mm[256];
  int m_type, m_test, m_cnt, m_rf, m_en, m_dout, m_row, pr, pc;
  initial foreach (mm[i]) mm[i] = -1;

  function automatic int rd_model(int row, int col, int tst);
    int v, base;
    if (!tst) return mm[row*16 + col];
    base = row*16 + (col/4)*4;
    v = 0;
    for (int b = 0; b < 4; b++) begin
      int ones = 0;
      for (int k = 0; k < 4; k++) begin
        if (mm[base+k] < 0) return -1;
        ones += (mm[base+k] >> b) & 1;
      end
      if (ones == 0 || ones == 4) v |= (1 << b);
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_type = 0; m_test = 0; m_cnt = 0; m_rf = 15; m_en = 0; m_dout = -1; m_row = 0; pr = 1; pc = 1;
    end else begin
      if (pr && !ras_n) begin
        if (cas_n) begin m_type = 2; m_row = addr; end
        else begin
          m_rf = m_cnt; m_cnt = (m_cnt + 1) % 16;
          m_type = we_n ? 3 : 4; m_test = we_n ? 0 : 1;
        end
      end else if (!pr && ras_n) begin
        if (m_type == 2) m_test = 0;
        m_type = 0;
      end else if (pc && !cas_n && !pr && !ras_n && (m_type == 1 || m_type == 2)) begin
        m_type = 1;
        if (!we_n) begin
          m_en = 0;
          for (int k = 0; k < 4; k++)
            if (m_test || k == addr % 4) mm[m_row*16 + (addr/4)*4 + k] = din;
        end else begin
          m_en = 1; m_dout = rd_model(m_row, addr, m_test);
        end
      end
      if (ras_n && cas_n) m_en = 0;
      pr = ras_n; pc = cas_n;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (cyc_type !== 3'(m_type)) begin failures++; $display("FAIL R1 cyc_type act=%0d exp=%0d", cyc_type, m_type); end
    else if (test_active !== 1'(m_test)) begin failures++; $display("FAIL R10 test_active act=%0d exp=%0d", test_active, m_test); end
    else if (rfsh_row !== 4'(m_rf)) begin failures++; $display("FAIL R4 rfsh_row act=%0d exp=%0d", rfsh_row, m_rf); end
    else if (dq_oe !== (m_en && !oe_n)) begin failures++; $display("FAIL R6 dq_oe act=%0b exp=%0b", dq_oe, m_en && !oe_n); end
    else if (dq_oe && m_dout >= 0 && dout !== 4'(m_dout)) begin failures++; $display("FAIL R5 dout act=%h exp=%h", dout, m_dout); end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic st(input logic r, c, w, o, input logic [3:0] a, d);
    @(negedge clk); ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; din = d;
  endtask
  task automatic obs; @(posedge clk); #1; endtask
  task automatic close; st(1,1,1,1,0,0); st(1,1,1,1,0,0); endtask
  task automatic wr(input logic [3:0] row, col, d);
    st(0,1,1,1,row,0); st(0,0,0,1,col,d); st(0,1,1,1,col,d); close;
  endtask
  task automatic rd(input logic [3:0] row, col, input logic o);
    st(0,1,1,o,row,0); st(0,0,1,o,col,0); st(0,1,1,o,col,0); obs;
  endtask
  task automatic refr(input logic w);
    st(1,0,w,1,4'hC,0); st(0,0,w,1,4'hC,0); st(0,0,1,1,0,0); obs; close;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++; $display("FAIL watchdog act=0 exp=1");
      done = 1; $display("TB_RESULT checks=%0d failures=%0d", checks, failures); $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    obs;
    chk(cyc_type == 0 && test_active == 0 && dq_oe == 0 && rfsh_row == 15, "R4 reset", rfsh_row, 15);
    // R1 row open then access
    st(0,1,1,1,4'd3,0); obs; chk(cyc_type == 2, "R1 row open", cyc_type, 2);
    st(0,0,0,1,4'd5,4'hA); obs; chk(cyc_type == 1, "R1 access", cyc_type, 1);
    chk(dq_oe == 0, "R5 write keeps output off", dq_oe, 0);
    st(0,1,1,1,0,0); close; obs; chk(cyc_type == 0, "R1 idle", cyc_type, 0);
    // R5 read back, R6 held after CAS rise
    rd(3,5,0); chk(dq_oe == 1 && dout == 4'hA, "R5 readback", dout, 4'hA);
    chk(dq_oe == 1, "R6 data held after column strobe rise", dq_oe, 1);
    close; obs; chk(dq_oe == 0, "R6 off after both high", dq_oe, 0);
    // R7
    rd(3,5,1); chk(dq_oe == 0, "R7 oe_n high", dq_oe, 0); close;
    // R6 hidden refresh
    st(0,1,1,0,4'd3,0); st(0,0,1,0,4'd5,0); st(1,0,1,0,0,0); st(0,0,1,0,0,0); obs;
    chk(cyc_type == 3 && dq_oe == 1 && dout == 4'hA, "R6 hidden refresh keeps data", dout, 4'hA);
    st(1,1,1,0,0,0); obs; chk(dq_oe == 0, "R6 hidden refresh end", dq_oe, 0); close;
    // R2 and R4 counter wrap
    for (int n = 0; n < 17; n++) begin
      logic [3:0] prev;
      prev = rfsh_row;
      st(1,0,1,1,4'h9,0); st(0,0,1,1,4'h9,0); obs;
      chk(cyc_type == 3, "R2 counter refresh", cyc_type, 3);
      chk(rfsh_row == prev + 4'd1, "R4 counter step", rfsh_row, prev + 4'd1);
      close;
    end
    // R3 test set, R8 parallel write
    refr(0); chk(test_active == 1, "R3 test entry", test_active, 1);
    wr(1,5,4'b1010);
    rd(1,6,0); chk(dout == 4'hF, "R8 group agrees", dout, 15); close;
    chk(test_active == 1, "R10 kept by read", test_active, 1);
    refr(1); chk(test_active == 0, "R10 exit by counter refresh", test_active, 0);
    rd(1,4,0); chk(dout == 4'b1010, "R8 copy in low cell", dout, 10); close;
    wr(1,4,4'b0101);
    refr(0); refr(0); chk(test_active == 1, "R10 kept by test set", test_active, 1);
    rd(1,7,0); chk(dout == 4'h0, "R9 group disagrees", dout, 0); close;
    st(0,1,1,1,4'd2,0); obs; close; obs;
    chk(test_active == 0, "R10 exit by row-only refresh", test_active, 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule